// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block carries data words from one clock domain to another that runs at an unrelated rate. Words are stored in a small dual-port memory. The write side and the read side each keep their own pointer, and a copy of each pointer passes to the other domain as Gray code through a two-stage synchronizer. Because only one bit of a Gray pointer changes per step, a sample taken mid-transition is either the old position or the new one. It is never an unrelated value.

Each side raises its hard flag in the very edge of its own clock that fills or drains the storage. A producer can therefore stop on the next cycle without losing a word. The flag is cleared only after the other side's pointer has made its way through the synchronizer. Each pointer is also kept as a binary count, and the synchronized Gray value is turned back into binary. This lets each side compute an occupancy figure and compare it with a threshold set by the user, which gives the early-warning flags. Those flags can trail the true occupancy by the synchronizer delay.

Top module: `xclk_fifo`

## Requirements
- R1: `full` goes to 1 at the write-clock edge that stores the 2^ADDR_W-th unread word. With one entry still free, `full` is 0.
- R2: `empty` goes to 1 at the read-clock edge that removes the last stored word. With one word still stored, `empty` is 0.
- R3: Once the other side's pointer has moved, `full` (or `empty`) stays at 1 through the next edge of its own clock and clears within four edges of its own clock.
- R4: While no read is crossing over, `almostFull` follows the write edges and equals (words stored >= `afThresh`). `afThresh` must lie in 1..2^ADDR_W.
- R5: While no write is crossing over, `almostEmpty` follows the read edges and equals (words stored <= `aeThresh`).
- R6: A write while `full` is 1 stores nothing and leaves the write pointer unchanged. A read while `empty` is 1 leaves `rdData` and the read pointer unchanged.
- R7: Words leave in the order they were written. `rdData` takes the word being read at the read-clock edge where `rdEn` is accepted.
- R8: While both resets are held, and after they are released, the outputs are `full`=0, `almostFull`=0, `empty`=1, `almostEmpty`=1 and `rdData`=0 until the first write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| wrRst | input | 1 | Write-side reset, active high, asserted asynchronously |
| wrEn | input | 1 | Request to store `wrData` at the next write edge |
| wrData | input | DATA_W | Word to store |
| afThresh | input | ADDR_W+1 | Occupancy at or above which `almostFull` is raised |
| rdClk | input | 1 | Read-side clock |
| rdRst | input | 1 | Read-side reset, active high, asserted asynchronously |
| rdEn | input | 1 | Request to remove the oldest word at the next read edge |
| aeThresh | input | ADDR_W+1 | Occupancy at or below which `almostEmpty` is raised |
| rdData | output | DATA_W | Most recently read word |
| full | output | 1 | No free entry (write domain) |
| almostFull | output | 1 | Write-side occupancy has reached `afThresh` |
| empty | output | 1 | No stored word (read domain) |
| almostEmpty | output | 1 | Read-side occupancy is at or below `aeThresh` |

## Verification
The assertions assume the following about the inputs:
- `afThresh` never exceeds the depth, so a full store always counts as almost full.
- Both thresholds are held steady.
- Each reset is released in step with its own clock.

The bench sets the thresholds before the resets are released and never changes them afterwards. It changes the request and data inputs one time unit after an edge of their own clock. It checks the exact-edge behaviour of the flags only when the other side's pointer has been idle long enough to settle. The release delay is tested only by counting edges of the flag's own clock after a single pointer step on the other side.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  // Accepted-transfer strobes from control to storage
  typedef struct packed {
    logic wrStb;  // write-clock domain: store word at wrAddr
    logic rdStb;  // read-clock domain: fetch word at rdAddr
  } memStb_t;
endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/xfifo_mem.sv
`timescale 1ns/1ps
module xfifo_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                 wrClk,
  input  logic                 rdClk,
  input  logic                 rdRst,
  input  xfifo_pkg::memStb_t   memStb,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (memStb.wrStb) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst)              rdData <= '0;
    else if (memStb.rdStb)  rdData <= store[rdAddr];
  end
endmodule

// File: rtl/xfifo_ctl.sv
`timescale 1ns/1ps
module xfifo_ctl #(
  parameter int ADDR_W = 4  // at least 2
) (
  input  logic                wrClk,
  input  logic                wrRst,
  input  logic                wrEn,
  input  logic [ADDR_W:0]     afThresh,
  input  logic                rdClk,
  input  logic                rdRst,
  input  logic                rdEn,
  input  logic [ADDR_W:0]     aeThresh,
  output xfifo_pkg::memStb_t  memStb,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic                full,
  output logic                almostFull,
  output logic                empty,
  output logic                almostEmpty
);
  localparam int PW = ADDR_W + 1;

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, wrBinNxt, wrGrayNxt;
  logic [PW-1:0] rdGraySync, rdBinSync, wrUsed, fullMatch;
  logic          wrGo;

  // ---------------- read domain -----------------
  logic [PW-1:0] rdBin, rdGray, rdBinNxt, rdGrayNxt;
  logic [PW-1:0] wrGraySync, wrBinSync, rdLeft;
  logic          rdGo;

  xfifo_sync #(.W(PW)) uRdToWr (
    .clk(wrClk), .rst(wrRst), .din(rdGray), .dout(rdGraySync)
  );
  xfifo_sync #(.W(PW)) uWrToRd (
    .clk(rdClk), .rst(rdRst), .din(wrGray), .dout(wrGraySync)
  );

  always_comb begin
    wrGo      = wrEn & ~full;
    wrBinNxt  = wrBin + {{ADDR_W{1'b0}}, wrGo};
    wrGrayNxt = wrBinNxt ^ (wrBinNxt >> 1);
    rdBinSync = grayToBin(rdGraySync);
    wrUsed    = wrBinNxt - rdBinSync;
    fullMatch = {~rdGraySync[PW-1:PW-2], rdGraySync[PW-3:0]};
  end

  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst) begin
      wrBin      <= '0;
      wrGray     <= '0;
      full       <= 1'b0;
      almostFull <= 1'b0;
    end else begin
      wrBin      <= wrBinNxt;
      wrGray     <= wrGrayNxt;
      full       <= (wrGrayNxt == fullMatch);
      almostFull <= (wrUsed >= afThresh);
    end
  end

  always_comb begin
    rdGo      = rdEn & ~empty;
    rdBinNxt  = rdBin + {{ADDR_W{1'b0}}, rdGo};
    rdGrayNxt = rdBinNxt ^ (rdBinNxt >> 1);
    wrBinSync = grayToBin(wrGraySync);
    rdLeft    = wrBinSync - rdBinNxt;
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      rdBin       <= '0;
      rdGray      <= '0;
      empty       <= 1'b1;
      almostEmpty <= 1'b1;
    end else begin
      rdBin       <= rdBinNxt;
      rdGray      <= rdGrayNxt;
      empty       <= (rdGrayNxt == wrGraySync);
      almostEmpty <= (rdLeft <= aeThresh);
    end
  end

  always_comb begin
    memStb.wrStb = wrGo;
    memStb.rdStb = rdGo;
    wrAddr       = wrBin[ADDR_W-1:0];
    rdAddr       = rdBin[ADDR_W-1:0];
  end
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W:0]   afThresh,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdEn,
  input  logic [ADDR_W:0]   aeThresh,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              almostFull,
  output logic              empty,
  output logic              almostEmpty
);
  xfifo_pkg::memStb_t      memStb;
  logic [ADDR_W-1:0]       wrAddr;
  logic [ADDR_W-1:0]       rdAddr;

  xfifo_ctl #(.ADDR_W(ADDR_W)) uCtl (
    .wrClk(wrClk), .wrRst(wrRst), .wrEn(wrEn), .afThresh(afThresh),
    .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn), .aeThresh(aeThresh),
    .memStb(memStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .almostFull(almostFull),
    .empty(empty), .almostEmpty(almostEmpty)
  );

  xfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uMem (
    .wrClk(wrClk), .rdClk(rdClk), .rdRst(rdRst), .memStb(memStb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              wrClk,
  input logic              wrRst,
  input logic              wrEn,
  input logic              rdClk,
  input logic              rdRst,
  input logic              rdEn,
  input logic              full,
  input logic              almostFull,
  input logic              empty,
  input logic              almostEmpty,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);
  // R6: refused write leaves the write pointer where it was
  a_r6_write_held: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrEn && full) |=> $stable(wrAddr));

  // R6: refused read leaves the read pointer and output word unchanged
  a_r6_read_held: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdEn && empty) |=> ($stable(rdData) && $stable(rdAddr)));

  // R4: a full store is always at or above the almost-full threshold
  a_r4_af_covers_full: assert property (@(posedge wrClk) disable iff (wrRst)
    full |-> almostFull);

  // R5: an empty store is always at or below the almost-empty threshold
  a_r5_ae_covers_empty: assert property (@(posedge rdClk) disable iff (rdRst)
    empty |-> almostEmpty);

  // R7: the output word only moves on an accepted read
  a_r7_data_on_read: assert property (@(posedge rdClk) disable iff (rdRst)
    !$past(rdEn) |-> $stable(rdData));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .wrClk(wrClk), .wrRst(wrRst), .wrEn(wrEn),
  .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn),
  .full(full), .almostFull(almostFull),
  .empty(empty), .almostEmpty(almostEmpty),
  .wrAddr(wrAddr), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/sim_xclk_fifo.sv
`timescale 1ns/1ps
module sim_xclk_fifo;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AF    = 12;
  localparam int AE    = 3;
  localparam int NSTREAM = 40;

  logic          wrClk = 1'b0, rdClk = 1'b0;
  logic          wrRst = 1'b1, rdRst = 1'b1;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [AW:0]   afThresh = AF[AW:0];
  logic [AW:0]   aeThresh = AE[AW:0];
  logic [DW-1:0] rdData;
  logic          full, almostFull, empty, almostEmpty;

  int nChk = 0;
  int nBad = 0;

  always #4   wrClk = ~wrClk;   // 125 MHz write clock
  always #5.5 rdClk = ~rdClk;   // unrelated read clock

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .wrClk(wrClk), .wrRst(wrRst), .wrEn(wrEn), .wrData(wrData), .afThresh(afThresh),
    .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn), .aeThresh(aeThresh),
    .rdData(rdData), .full(full), .almostFull(almostFull),
    .empty(empty), .almostEmpty(almostEmpty)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wrOne(input logic [DW-1:0] d);
    @(posedge wrClk); #1 wrEn = 1'b1; wrData = d;
    @(posedge wrClk); #1 wrEn = 1'b0;
  endtask

  task automatic rdOne(output logic [DW-1:0] d);
    @(posedge rdClk); #1 rdEn = 1'b1;
    @(posedge rdClk); #1 rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic settle();
    repeat (6) @(posedge wrClk);
    repeat (6) @(posedge rdClk);
    #1;
  endtask

  // R8: outputs after reset
  task automatic tReset();
    chk("R8", "full after reset", full, 0);
    chk("R8", "almostFull after reset", almostFull, 0);
    chk("R8", "empty after reset", empty, 1);
    chk("R8", "almostEmpty after reset", almostEmpty, 1);
    chk("R8", "rdData after reset", rdData, 0);
  endtask

  // R1, R4: fill from empty, flags follow each write edge
  task automatic tFill();
    for (int i = 0; i < DEPTH; i++) begin
      wrOne(8'hA0 + 8'(i));
      chk("R1", $sformatf("full after write %0d", i + 1), full, (i + 1 == DEPTH) ? 1 : 0);
      chk("R4", $sformatf("almostFull after write %0d", i + 1), almostFull, (i + 1 >= AF) ? 1 : 0);
    end
  endtask

  // R6: write while full is dropped
  task automatic tOverflow();
    wrOne(8'h55);
    chk("R6", "full after refused write", full, 1);
  endtask

  // R3: full released only after the read pointer crosses over
  task automatic tReleaseFull();
    logic [DW-1:0] d;
    rdOne(d);
    chk("R7", "first word out", d, 8'hA0);
    @(posedge wrClk); #1;
    chk("R3", "full held one write edge after read", full, 1);
    repeat (4) @(posedge wrClk); #1;
    chk("R3", "full released within four write edges", full, 0);
    wrOne(8'hB0);
    chk("R1", "full after refill", full, 1);
  endtask

  // R2, R5, R6, R7: drain all words in order
  task automatic tDrain();
    logic [DW-1:0] d;
    logic [DW-1:0] exp;
    settle();
    for (int k = 1; k <= DEPTH; k++) begin
      rdOne(d);
      exp = (k == DEPTH) ? 8'hB0 : 8'hA0 + 8'(k);
      chk("R7", $sformatf("drain word %0d", k), d, exp);
      chk("R2", $sformatf("empty after read %0d", k), empty, (k == DEPTH) ? 1 : 0);
      chk("R5", $sformatf("almostEmpty after read %0d", k), almostEmpty, (DEPTH - k <= AE) ? 1 : 0);
    end
  endtask

  // R6: read while empty changes nothing
  task automatic tUnderflow();
    logic [DW-1:0] d;
    rdOne(d);
    chk("R6", "rdData after refused read", d, 8'hB0);
    chk("R6", "empty after refused read", empty, 1);
  endtask

  // R3, R6: empty released only after the write pointer crosses over
  task automatic tReleaseEmpty();
    logic [DW-1:0] d;
    wrOne(8'hC3);
    @(posedge rdClk); #1;
    chk("R3", "empty held one read edge after write", empty, 1);
    repeat (4) @(posedge rdClk); #1;
    chk("R3", "empty released within four read edges", empty, 0);
    rdOne(d);
    chk("R6", "word after refused read", d, 8'hC3);
    chk("R2", "empty after single read", empty, 1);
  endtask

  // R7: concurrent streaming, order kept
  task automatic tStream();
    int errs = 0;
    fork
      begin
        int sent = 0;
        while (sent < NSTREAM) begin
          @(posedge wrClk); #1;
          if (!full) begin
            wrEn = 1'b1; wrData = 8'((sent * 37 + 5) & 255); sent++;
          end else wrEn = 1'b0;
        end
        @(posedge wrClk); #1 wrEn = 1'b0;
      end
      begin
        int got = 0;
        bit pend = 1'b0;
        while (got < NSTREAM) begin
          @(posedge rdClk); #1;
          if (pend) begin
            if (rdData !== 8'((got * 37 + 5) & 255)) errs++;
            got++;
          end
          if (!empty && got + (pend ? 0 : 0) < NSTREAM && got < NSTREAM) begin
            rdEn = 1'b1; pend = 1'b1;
          end else begin
            rdEn = 1'b0; pend = 1'b0;
          end
        end
        rdEn = 1'b0;
      end
    join
    chk("R7", "stream mismatches", errs, 0);
    settle();
    chk("R2", "empty after stream", empty, 1);
  endtask

  initial begin
    repeat (3) @(posedge wrClk); #1 wrRst = 1'b0;
    @(posedge rdClk); #1 rdRst = 1'b0;
    settle();
    tReset();
    tFill();
    tOverflow();
    tReleaseFull();
    tDrain();
    tUnderflow();
    tReleaseEmpty();
    tStream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wrClk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule